// File: doc/BRIEF.md
# Supply supervisor with watchdog

This block is a clocked reset supervisor. It watches two supply comparator flags, a lower and an upper level, and a heartbeat line from a monitored processor. It drives a pair of complementary system reset outputs. Reset is held after power comes up, released after a fixed hold time, and asserted again if the supply sags or if the processor stops sending heartbeats.

All timing comes from one up/down counter that models a charging and discharging capacitor. From zero, the counter ramps up by one per cycle through the power-on hold. It then ramps down by one per cycle while it waits for a heartbeat. On each heartbeat it ramps up quickly, five units per cycle. The same fast ramp times the reset pulse that a watchdog timeout produces. A single parameter, `WD_CYC`, sets every duration. The power-on hold is `10*WD_CYC` cycles, the watchdog timeout is `WD_CYC` cycles and the watchdog reset pulse is `WD_CYC/5` cycles. A synchronous forced-reset input acts like a supply failure. An inhibit input parks the counter at a middle level, which stops watchdog resets while supply monitoring keeps running.

Top module: `supply_supervisor`

## Requirements
- R1: While `arst_n` is low, `sys_reset` is 1 and `sys_reset_n` is 0, and the counter is zero. The first release after `arst_n` rises therefore takes the full power-on hold.
- R2: `sys_reset_n` is always the exact inverse of `sys_reset`.
- R3: If `sup_lo_ok` is 0 at a rising edge, `sys_reset` is 1 after that edge and the counter is cleared. This holds even while `wd_inhibit` is 1.
- R4: Once the supply has failed, reset stays asserted while `sup_hi_ok` is 0, even when `sup_lo_ok` is 1 again. This is the hysteresis between the two flags.
- R5: The first edge that sees `sup_lo_ok`=1, `sup_hi_ok`=1 and `force_rst`=0 starts the power-on hold. `sys_reset` falls `10*WD_CYC` edges later, so it is low after the `10*WD_CYC+1`-th edge counted from that input change.
- R6: Heartbeat edges have no effect during the power-on hold or during a watchdog reset pulse. Neither duration changes.
- R7: With no heartbeat, `sys_reset` rises exactly `WD_CYC` edges after it was released.
- R8: A watchdog reset pulse lasts `WD_CYC/5` edges. Afterwards the discharge restarts from the top, so the next timeout is again `WD_CYC` edges.
- R9: A heartbeat is a falling edge on `hb_in`: high, then low for at least two consecutive clock samples. It restarts charging. A low that lasts one clock is ignored. Heartbeats at intervals well below `WD_CYC` keep reset deasserted, and a single heartbeat delays the next reset by between `WD_CYC` and `WD_CYC+WD_CYC/5` cycles plus the synchronizer latency.
- R10: While `wd_inhibit` is 1 and reset is released, the counter sits at the middle level (`WD_CYC/2` above the lower threshold) and no watchdog reset occurs. After inhibit drops, the timeout is `WD_CYC/2` edges. Inhibit has no effect during the power-on hold.
- R11: A 1 on `force_rst` at a rising edge asserts reset after that edge, clears the counter and requires the full power-on hold once it returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| sup_lo_ok | input | 1 | Supply is above the lower threshold |
| sup_hi_ok | input | 1 | Supply is above the upper threshold |
| hb_in | input | 1 | Heartbeat from the monitored processor (asynchronous, falling edge active) |
| force_rst | input | 1 | Synchronous forced reset, active high |
| wd_inhibit | input | 1 | Parks the watchdog at its middle level |
| sys_reset | output | 1 | System reset, active high |
| sys_reset_n | output | 1 | System reset, active low |

## Verification
The assertions assume that `sup_lo_ok`, `sup_hi_ok`, `force_rst` and `wd_inhibit` are already synchronous to `clk`, and that `sup_hi_ok` is never 1 while `sup_lo_ok` is 0. They also assume that `WD_CYC` is a multiple of five and at least ten, so the fast ramp lands exactly on the upper threshold. The stimulus changes every input only on falling clock edges. It raises the upper flag only when the lower flag is already high. Only the heartbeat line is driven without regard to the counter phase, because it is the one input the block resynchronizes.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

  typedef enum logic [2:0] {
    PH_HOLD,   // supply bad or forced: counter cleared
    PH_POR,    // power-on hold: slow charge
    PH_DIS,    // watchdog discharge
    PH_CHG,    // recharge after heartbeat
    PH_WDR     // watchdog reset pulse: fast charge
  } phase_t;

  typedef enum logic [2:0] {
    OP_CLEAR,
    OP_KEEP,
    OP_UP1,
    OP_DOWN1,
    OP_FAST,
    OP_MID
  } ramp_op_t;

  localparam int unsigned POR_MULT = 10;
  localparam int unsigned FAST_DIV = 5;

  function automatic int unsigned ramp_top(input int unsigned wd);
    return POR_MULT * wd;
  endfunction

  function automatic int unsigned ramp_floor(input int unsigned wd);
    return (POR_MULT - 1) * wd;
  endfunction

  function automatic int unsigned ramp_mid(input int unsigned wd);
    return ramp_floor(wd) + wd / 2;
  endfunction

  function automatic int unsigned ramp_width(input int unsigned wd);
    return $clog2(ramp_top(wd) + 1);
  endfunction

endpackage

// File: rtl/supsv_hb_sync.sv
module supsv_hb_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hb_in,
  output logic hb_fall
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   hist1_q;
  logic                   hist2_q;
  logic                   hb_s;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[i] <= 1'b1;
        else         chain_q[i] <= hb_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[i] <= 1'b1;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign hb_s = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hist1_q <= 1'b1;
      hist2_q <= 1'b1;
    end else begin
      hist1_q <= hb_s;
      hist2_q <= hist1_q;
    end
  end

  // high, then two consecutive low samples
  assign hb_fall = hist2_q & ~hist1_q & ~hb_s;

  assert_fall_spaced_R9: assert property (
    @(posedge clk) disable iff (!arst_n) hb_fall |=> !hb_fall);

endmodule

// File: rtl/supsv_ramp.sv
module supsv_ramp
  import supsv_pkg::*;
#(
  parameter int unsigned WD_CYC = 40,
  parameter int unsigned CW     = 9
) (
  input  logic          clk,
  input  logic          arst_n,
  input  ramp_op_t      op,
  output logic [CW-1:0] cnt,
  output logic          por_done,
  output logic          fast_done,
  output logic          floor_hit
);

  localparam logic [CW-1:0] TOP_V   = CW'(ramp_top(WD_CYC));
  localparam logic [CW-1:0] FLOOR_V = CW'(ramp_floor(WD_CYC));
  localparam logic [CW-1:0] MID_V   = CW'(ramp_mid(WD_CYC));
  localparam logic [CW-1:0] STEP_V  = CW'(FAST_DIV);
  localparam logic [CW-1:0] ONE_V   = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign por_done  = (cnt_q == TOP_V - ONE_V);
  assign fast_done = (cnt_q >= TOP_V - STEP_V);
  assign floor_hit = (cnt_q == FLOOR_V + ONE_V);

  always_comb begin
    unique case (op)
      OP_CLEAR: cnt_d = '0;
      OP_UP1:   cnt_d = cnt_q + ONE_V;
      OP_DOWN1: cnt_d = cnt_q - ONE_V;
      OP_FAST:  cnt_d = fast_done ? TOP_V : cnt_q + STEP_V;
      OP_MID:   cnt_d = MID_V;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_ramp_bound_R8: assert property (
    @(posedge clk) disable iff (!arst_n) cnt_q <= TOP_V);

endmodule

// File: rtl/supsv_phase_ctl.sv
module supsv_phase_ctl
  import supsv_pkg::*;
(
  input  logic     clk,
  input  logic     arst_n,
  input  logic     sup_lo_ok,
  input  logic     sup_hi_ok,
  input  logic     force_rst,
  input  logic     wd_inhibit,
  input  logic     hb_fall,
  input  logic     por_done,
  input  logic     fast_done,
  input  logic     floor_hit,
  output ramp_op_t op,
  output logic     rst_d
);

  phase_t ph_q;
  phase_t ph_d;
  logic   fail_now;

  assign fail_now = ~sup_lo_ok | force_rst;

  always_comb begin
    ph_d = ph_q;
    op   = OP_KEEP;
    if (fail_now) begin
      ph_d = PH_HOLD;
      op   = OP_CLEAR;
    end else begin
      unique case (ph_q)
        PH_HOLD: begin
          op = OP_CLEAR;
          if (sup_hi_ok) ph_d = PH_POR;
        end
        PH_POR: begin
          op = OP_UP1;
          if (por_done) ph_d = PH_DIS;
        end
        PH_DIS: begin
          if (wd_inhibit) begin
            op = OP_MID;
          end else if (hb_fall) begin
            ph_d = PH_CHG;
          end else begin
            op = OP_DOWN1;
            if (floor_hit) ph_d = PH_WDR;
          end
        end
        default: begin  // PH_CHG, PH_WDR
          if (wd_inhibit) begin
            ph_d = PH_DIS;
            op   = OP_MID;
          end else begin
            op = OP_FAST;
            if (fast_done) ph_d = PH_DIS;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) ph_q <= PH_HOLD;
    else         ph_q <= ph_d;
  end

  assign rst_d = (ph_d == PH_HOLD) | (ph_d == PH_POR) | (ph_d == PH_WDR);

  assert_hold_hyst_R4: assert property (
    @(posedge clk) disable iff (!arst_n)
    (ph_q == PH_HOLD && !sup_hi_ok) |=> (ph_q == PH_HOLD));

  assert_por_ignores_hb_R6: assert property (
    @(posedge clk) disable iff (!arst_n)
    (ph_q == PH_POR && !fail_now) |=> (ph_q == PH_POR || ph_q == PH_DIS));

  assert_timeout_R7: assert property (
    @(posedge clk) disable iff (!arst_n)
    (ph_q == PH_DIS && !fail_now && !wd_inhibit && !hb_fall && floor_hit)
      |=> (ph_q == PH_WDR));

  assert_pulse_holds_R8: assert property (
    @(posedge clk) disable iff (!arst_n)
    (ph_q == PH_WDR && !fail_now && !wd_inhibit && !fast_done)
      |=> (ph_q == PH_WDR));

  assert_force_R11: assert property (
    @(posedge clk) disable iff (!arst_n) force_rst |=> (ph_q == PH_HOLD));

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supsv_pkg::*;
#(
  parameter int unsigned WD_CYC      = 40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic sup_lo_ok,
  input  logic sup_hi_ok,
  input  logic hb_in,
  input  logic force_rst,
  input  logic wd_inhibit,
  output logic sys_reset,
  output logic sys_reset_n
);

  localparam int unsigned   CW    = ramp_width(WD_CYC);
  localparam logic [CW-1:0] MID_V = CW'(ramp_mid(WD_CYC));

  ramp_op_t      op;
  logic [CW-1:0] cnt;
  logic          hb_fall;
  logic          por_done;
  logic          fast_done;
  logic          floor_hit;
  logic          rst_d;
  logic          rst_q;
  logic          rstn_q;

  supsv_hb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .hb_in   (hb_in),
    .hb_fall (hb_fall)
  );

  supsv_ramp #(.WD_CYC(WD_CYC), .CW(CW)) u_ramp (
    .clk       (clk),
    .arst_n    (arst_n),
    .op        (op),
    .cnt       (cnt),
    .por_done  (por_done),
    .fast_done (fast_done),
    .floor_hit (floor_hit)
  );

  supsv_phase_ctl u_ctl (
    .clk        (clk),
    .arst_n     (arst_n),
    .sup_lo_ok  (sup_lo_ok),
    .sup_hi_ok  (sup_hi_ok),
    .force_rst  (force_rst),
    .wd_inhibit (wd_inhibit),
    .hb_fall    (hb_fall),
    .por_done   (por_done),
    .fast_done  (fast_done),
    .floor_hit  (floor_hit),
    .op         (op),
    .rst_d      (rst_d)
  );

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_q  <= 1'b1;
      rstn_q <= 1'b0;
    end else begin
      rst_q  <= rst_d;
      rstn_q <= ~rst_d;
    end
  end

  assign sys_reset   = rst_q;
  assign sys_reset_n = rstn_q;

  assert_complement_R2: assert property (
    @(posedge clk) disable iff (!arst_n) sys_reset != sys_reset_n);

  assert_supply_fail_R3: assert property (
    @(posedge clk) disable iff (!arst_n)
    !sup_lo_ok |=> (sys_reset && cnt == '0));

  assert_inhibit_mid_R10: assert property (
    @(posedge clk) disable iff (!arst_n)
    (wd_inhibit && sup_lo_ok && !force_rst && !sys_reset)
      |=> (cnt == MID_V && !sys_reset));

endmodule

// File: tb/supply_supervisor_test.sv
module supply_supervisor_test;

  localparam int WD   = 40;
  localparam int POR  = 10 * WD;
  localparam int WDR  = WD / 5;
  localparam int HALF = WD / 2;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic sup_lo_ok = 1'b0;
  logic sup_hi_ok = 1'b0;
  logic hb_in = 1'b1;
  logic force_rst = 1'b0;
  logic wd_inhibit = 1'b0;
  logic sys_reset;
  logic sys_reset_n;

  int vectors = 0;
  int miscompares = 0;
  int comp_bad = 0;

  always #4 clk = ~clk;

  supply_supervisor #(.WD_CYC(WD)) uut (
    .clk         (clk),
    .arst_n      (arst_n),
    .sup_lo_ok   (sup_lo_ok),
    .sup_hi_ok   (sup_hi_ok),
    .hb_in       (hb_in),
    .force_rst   (force_rst),
    .wd_inhibit  (wd_inhibit),
    .sys_reset   (sys_reset),
    .sys_reset_n (sys_reset_n)
  );

  // R2 monitor
  always @(negedge clk) if (sys_reset == sys_reset_n) comp_bad++;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    vectors++;
    if (act < lo || act > hi) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_level(input logic lvl, input int lim, output int n);
    n = 0;
    while (n < lim) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (sys_reset == lvl) break;
    end
  endtask

  task automatic stay_level(input logic lvl, input int cyc, output int bad);
    bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); @(negedge clk);
      if (sys_reset != lvl) bad++;
    end
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R1 reset out", int'(sys_reset), 1);
    chk("R1 reset_n out", int'(sys_reset_n), 0);
    arst_n = 1'b1;
  endtask

  task automatic t_hysteresis();
    int bad;
    sup_lo_ok = 1'b1; sup_hi_ok = 1'b0;
    stay_level(1'b1, 600, bad);
    chk("R4 held between flags", bad, 0);
  endtask

  task automatic t_power_up_hb();
    int n = 0;
    sup_hi_ok = 1'b1;
    while (n < POR + 20) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!sys_reset) break;
      if (n < POR - 20) begin
        if (n % 7 == 0) hb_in = ~hb_in;
      end else hb_in = 1'b1;
    end
    chk("R5 R6 R1 power-on hold", n, POR + 1);
  endtask

  task automatic t_timeout();
    int n;
    wait_level(1'b1, 200, n); chk("R7 timeout", n, WD);
    wait_level(1'b0, 200, n); chk("R8 pulse width", n, WDR);
    wait_level(1'b1, 200, n); chk("R8 discharge restart", n, WD);
  endtask

  task automatic t_hb_in_pulse();
    int n = 0;
    while (n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!sys_reset) break;
      hb_in = ((n / 2) % 2 == 0);
    end
    hb_in = 1'b1;
    chk("R6 pulse ignores heartbeat", n, WDR);
    wait_level(1'b1, 200, n);
    wait_level(1'b0, 200, n);
  endtask

  task automatic t_glitch();
    int n = 0;
    while (n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (sys_reset) break;
      hb_in = (n % 10 == 5) ? 1'b0 : 1'b1;
    end
    hb_in = 1'b1;
    chk("R9 one-clock low ignored", n, WD);
    wait_level(1'b0, 200, n);
  endtask

  task automatic t_keepalive();
    int bad = 0;
    int n;
    for (int i = 0; i < 600; i++) begin
      hb_in = ((i / 10) % 2 == 1) ? 1'b0 : 1'b1;
      @(posedge clk); @(negedge clk);
      if (sys_reset) bad++;
    end
    chk("R9 keepalive", bad, 0);
    hb_in = 1'b1;
    repeat (12) @(negedge clk);
    hb_in = 1'b0;
    n = 0;
    while (n < 200) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 3) hb_in = 1'b1;
      if (sys_reset) break;
    end
    chk_range("R9 detection latency", n, 44, 53);
    wait_level(1'b0, 200, n);
  endtask

  task automatic t_inhibit();
    int bad;
    int n;
    wd_inhibit = 1'b1;
    stay_level(1'b0, 500, bad);
    chk("R10 no timeout while inhibited", bad, 0);
    wd_inhibit = 1'b0;
    wait_level(1'b1, 200, n); chk("R10 timeout from mid", n, HALF);
    wait_level(1'b0, 200, n);
  endtask

  task automatic t_fail_inhibited();
    int bad;
    int n;
    wd_inhibit = 1'b1;
    repeat (5) @(negedge clk);
    sup_lo_ok = 1'b0; sup_hi_ok = 1'b0;
    @(negedge clk);
    chk("R3 fail during inhibit", int'(sys_reset), 1);
    sup_lo_ok = 1'b1;
    stay_level(1'b1, 100, bad);
    chk("R4 recover needs high flag", bad, 0);
    sup_hi_ok = 1'b1;
    wait_level(1'b0, POR + 20, n);
    chk("R3 R10 full hold after fail", n, POR + 1);
    stay_level(1'b0, 100, bad);
    chk("R10 inhibit after release", bad, 0);
    wd_inhibit = 1'b0;
    wait_level(1'b1, 200, n); chk("R10 mid after hold", n, HALF);
    wait_level(1'b0, 200, n);
  endtask

  task automatic t_force();
    int n;
    force_rst = 1'b1;
    @(negedge clk);
    chk("R11 force asserts", int'(sys_reset), 1);
    force_rst = 1'b0;
    wait_level(1'b0, POR + 20, n);
    chk("R11 full hold after force", n, POR + 1);
  endtask

  task automatic t_drop();
    int n;
    repeat (7) @(negedge clk);
    sup_lo_ok = 1'b0;
    @(negedge clk);
    chk("R3 drop asserts next edge", int'(sys_reset), 1);
    sup_lo_ok = 1'b1;
    wait_level(1'b0, POR + 20, n);
    chk("R3 counter cleared", n, POR + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset_state();
    t_hysteresis();
    t_power_up_hb();
    t_timeout();
    t_hb_in_pulse();
    t_glitch();
    t_keepalive();
    t_inhibit();
    t_fail_inhibited();
    t_force();
    t_drop();
    chk("R2 complement", comp_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule